// File: doc/BRIEF.md
# Double-Edge Address Strobe Capture

This block recovers address bits from a source-synchronous lane in which one strobe marks two bits per bus period: the strobe's high-to-low transition marks the even bit and its low-to-high transition marks the odd bit. The block runs on a local clock much faster than the strobe. It passes the strobe and the address line through a synchronizer chain of equal depth, so the two stay aligned. It then finds both strobe transitions. Which bit slot is filled depends only on the polarity of the transition, not on a slot counter.

Each completed pair is presented as a two-bit word with a one-cycle valid pulse. A separate monitor raises an idle indication once the strobe and the address line have both been high for a programmable number of local clocks. Two sticky flags report broken transfers. The first covers a pair whose second transition never arrives, in which case the half pair is dropped. The second covers a low-to-high transition that has no half pair waiting for it.

Top module: `strobe_pair_capture`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pair_valid`, `pair_data`, `bus_idle`, `proto_err` and `len_err` are all 0.
- R2: The address value at the strobe's falling transition is placed in `pair_data[0]`. The value at the following rising transition is placed in `pair_data[1]`. `pair_valid` is high for exactly one clock per completed pair.
- R3: With SYNC_STAGES = 2, `pair_valid` rises on the third rising clock edge after the strobe input goes high.
- R4: Back-to-back pairs each produce exactly one word, in arrival order. A transfer of any even number of bits produces half that many words and no flag.
- R5: `bus_idle` rises on the (idle_thresh + 2)-th clock edge after the strobe and address inputs are both high. An `idle_thresh` of 0 acts as 1.
- R6: `bus_idle` falls on the third clock edge after either the strobe or the address input goes low.
- R7: A high strobe with a low address line never counts toward idle.
- R8: If the strobe stays low for `idle_thresh` synchronized clocks after a falling transition, `len_err` is set and the lone bit is discarded without a `pair_valid`.
- R9: A rising transition with no half pair waiting sets `proto_err` and produces no `pair_valid`.
- R10: `proto_err` and `len_err` stay set through later valid pairs and clear only on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| strb_in | input | 1 | Asynchronous address strobe |
| addr_in | input | 1 | Asynchronous address line |
| idle_thresh | input | CNT_W | Local clocks of quiet (or low-strobe wait) before idle or timeout |
| pair_data | output | 2 | Captured pair, even bit in bit 0 |
| pair_valid | output | 1 | One-cycle pulse per completed pair |
| bus_idle | output | 1 | Strobe and address held high long enough |
| proto_err | output | 1 | Sticky: rising transition without a pending bit |
| len_err | output | 1 | Sticky: falling transition never completed |

## Verification
All four two-bit combinations are sent back to back in mixed orders. Swapped bit slots or an inverted polarity decode show up as wrong words, and missed or doubled edges show up as a wrong word count. The idle monitor is run with a high strobe and a low address line, and with both high, to separate the two conditions. Its rise and fall edges are sampled at exact cycles, so an extra or missing register stage shows. A transfer stopped after its falling transition shows the timeout drop, and the late rising transition that follows shows the orphan-edge flag. The flags are then checked to survive a good pair.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HALF  = 1'b1
    } pair_state_e;

    typedef struct packed {
        logic strobe;
        logic addr;
    } lane_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } pair_t;

    localparam int LANE_W = $bits(lane_t);

    // A threshold of zero is treated as one.
    function automatic int unsigned eff_limit(input int unsigned t);
        return (t == 0) ? 1 : t;
    endfunction

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= '1;
                    else     chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= '1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spc_edge.sv
module spc_edge
    import spc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t cur,
    output logic  rise,
    output logic  fall
);
    logic prev_strobe;

    always_ff @(posedge clk) begin
        if (rst) prev_strobe <= 1'b1;
        else     prev_strobe <= cur.strobe;
    end

    assign rise = !prev_strobe &&  cur.strobe;
    assign fall =  prev_strobe && !cur.strobe;
endmodule

// File: rtl/spc_pair_fsm.sv
module spc_pair_fsm
    import spc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             fall,
    input  logic             addr,
    input  logic [CNT_W-1:0] limit,
    output pair_t            pair_q,
    output logic             valid,
    output logic             perr,
    output logic             lerr,
    output pair_state_e      st
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             lo_bit;
    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] low_nxt;
    logic [CNT_W-1:0] lim_eff;
    logic             low_hit;

    assign lim_eff = CNT_W'(eff_limit(32'(limit)));
    assign low_nxt = (low_cnt == CNT_MAX) ? low_cnt : low_cnt + 1'b1;
    assign low_hit = (low_nxt >= lim_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_EMPTY;
            lo_bit  <= 1'b0;
            low_cnt <= '0;
            pair_q  <= '0;
            valid   <= 1'b0;
            perr    <= 1'b0;
            lerr    <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (st)
                ST_EMPTY: begin
                    if (fall) begin
                        lo_bit  <= addr;
                        low_cnt <= '0;
                        st      <= ST_HALF;
                    end else if (rise) begin
                        perr <= 1'b1;
                    end
                end
                ST_HALF: begin
                    if (rise) begin
                        pair_q <= '{hi: addr, lo: lo_bit};
                        valid  <= 1'b1;
                        st     <= ST_EMPTY;
                    end else if (low_hit) begin
                        lerr <= 1'b1;
                        st   <= ST_EMPTY;
                    end else begin
                        low_cnt <= low_nxt;
                    end
                end
                default: st <= ST_EMPTY;
            endcase
        end
    end
endmodule

// File: rtl/spc_idle_mon.sv
module spc_idle_mon
    import spc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_t            lane,
    input  logic [CNT_W-1:0] limit,
    output logic             idle
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] lim_eff;
    logic             quiet;

    assign quiet   = lane.strobe && lane.addr;
    assign lim_eff = CNT_W'(eff_limit(32'(limit)));
    assign cnt_nxt = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            idle <= 1'b0;
        end else if (!quiet) begin
            cnt  <= '0;
            idle <= 1'b0;
        end else begin
            cnt  <= cnt_nxt;
            idle <= (cnt_nxt >= lim_eff);
        end
    end
endmodule

// File: rtl/strobe_pair_capture.sv
module strobe_pair_capture
    import spc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strb_in,
    input  logic             addr_in,
    input  logic [CNT_W-1:0] idle_thresh,
    output logic [1:0]       pair_data,
    output logic             pair_valid,
    output logic             bus_idle,
    output logic             proto_err,
    output logic             len_err
);
    lane_t       raw_lane;
    lane_t       sy_lane;
    logic        rise;
    logic        fall;
    pair_t       pair_q;
    pair_state_e st;

    assign raw_lane = '{strobe: strb_in, addr: addr_in};

    spc_sync #(.W(LANE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lane),
        .q   (sy_lane)
    );

    spc_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .cur  (sy_lane),
        .rise (rise),
        .fall (fall)
    );

    spc_pair_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .rise   (rise),
        .fall   (fall),
        .addr   (sy_lane.addr),
        .limit  (idle_thresh),
        .pair_q (pair_q),
        .valid  (pair_valid),
        .perr   (proto_err),
        .lerr   (len_err),
        .st     (st)
    );

    spc_idle_mon #(.CNT_W(CNT_W)) u_idle (
        .clk   (clk),
        .rst   (rst),
        .lane  (sy_lane),
        .limit (idle_thresh),
        .idle  (bus_idle)
    );

    assign pair_data = pair_q;
endmodule

// File: rtl/spc_chk.sv
module spc_chk
    import spc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rise,
    input logic        pair_valid,
    input logic        proto_err,
    input logic        len_err,
    input pair_state_e st
);
    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid);

    // R2
    valid_source_chk: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> ($past(st) == ST_HALF && $past(rise)));

    // R9
    orphan_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && st == ST_EMPTY) |=> (proto_err && !pair_valid));

    // R10
    proto_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R10
    len_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        len_err |=> len_err);

    // R8
    len_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(len_err) |-> !pair_valid);
endmodule

bind strobe_pair_capture spc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rise       (rise),
    .pair_valid (pair_valid),
    .proto_err  (proto_err),
    .len_err    (len_err),
    .st         (st)
);

// File: tb/sim_strobe_pair_capture.sv
module sim_strobe_pair_capture;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    // [3] driven odd bit, [2] driven even bit, [1:0] expected word
    localparam logic [3:0] VEC [8] = '{4'b0000, 4'b0101, 4'b1010, 4'b1111,
                                       4'b0101, 4'b0000, 4'b1010, 4'b1111};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strb_in = 1'b1;
    logic          addr_in = 1'b1;
    logic [CW-1:0] idle_thresh = 8'd12;
    logic [1:0]    pair_data;
    logic          pair_valid;
    logic          bus_idle;
    logic          proto_err;
    logic          len_err;

    int   n_chk = 0;
    int   n_bad = 0;
    int   n_cap = 0;
    logic [1:0] last_cap = 2'b00;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_pair_capture #(.SYNC_STAGES(2), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .strb_in(strb_in), .addr_in(addr_in),
        .idle_thresh(idle_thresh), .pair_data(pair_data),
        .pair_valid(pair_valid), .bus_idle(bus_idle),
        .proto_err(proto_err), .len_err(len_err)
    );

    always @(negedge clk) begin
        if (!rst && pair_valid) begin
            n_cap++;
            last_cap = pair_data;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_pair(input logic b0, input logic b1);
        addr_in = b0; tick(2);
        strb_in = 1'b0; tick(2);
        addr_in = b1; tick(2);
        strb_in = 1'b1; tick(2);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        int base;
        tick(3);
        // R1 during reset
        check(!pair_valid && !bus_idle && !proto_err && !len_err && pair_data == 2'b00,
              "R1", {pair_valid, bus_idle, proto_err, len_err}, 0);
        rst = 1'b0;
        tick(1);
        check(!pair_valid && !bus_idle && !proto_err && !len_err, "R1",
              {pair_valid, bus_idle, proto_err, len_err}, 0);

        // R2 / R4: table of pairs sent back to back
        for (int i = 0; i < 8; i++) begin
            base = n_cap;
            send_pair(VEC[i][2], VEC[i][3]);
            tick(2);
            check(n_cap == base + 1, "R4", n_cap - base, 1);
            check(last_cap == VEC[i][1:0], "R2", last_cap, VEC[i][1:0]);
        end
        check(!proto_err && !len_err, "R4", {proto_err, len_err}, 0);

        // R3: exact latency from the rising strobe input
        addr_in = 1'b1; tick(2); strb_in = 1'b0; tick(2);
        addr_in = 1'b0; tick(2);
        base = n_cap;
        strb_in = 1'b1;
        tick(1); check(!pair_valid, "R3", pair_valid, 0);
        tick(1); check(!pair_valid, "R3", pair_valid, 0);
        tick(1); check(pair_valid && pair_data == 2'b01, "R3", {pair_valid, pair_data}, 5);
        tick(1); check(!pair_valid, "R2", pair_valid, 0);

        // R7: strobe high, address low never idles
        idle_thresh = 8'd5;
        addr_in = 1'b0; tick(12);
        check(!bus_idle, "R7", bus_idle, 0);

        // R5: idle after exactly thresh + 2 edges
        addr_in = 1'b1;
        tick(6); check(!bus_idle, "R5", bus_idle, 0);
        tick(1); check(bus_idle, "R5", bus_idle, 1);

        // R6: idle drops on third edge after address low
        addr_in = 1'b0;
        tick(2); check(bus_idle, "R6", bus_idle, 1);
        tick(1); check(!bus_idle, "R6", bus_idle, 0);
        addr_in = 1'b1; tick(8);

        // R8: falling transition never completed
        idle_thresh = 8'd6;
        base = n_cap;
        strb_in = 1'b0; tick(15);
        check(len_err, "R8", len_err, 1);
        check(!proto_err, "R8", proto_err, 0);
        check(n_cap == base, "R8", n_cap - base, 0);

        // R9: the late rising transition has no pending bit
        strb_in = 1'b1; tick(5);
        check(proto_err, "R9", proto_err, 1);
        check(n_cap == base, "R9", n_cap - base, 0);

        // R10: flags survive a good pair
        idle_thresh = 8'd12;
        base = n_cap;
        send_pair(1'b0, 1'b1); tick(2);
        check(n_cap == base + 1 && last_cap == 2'b10, "R10", last_cap, 2);
        check(proto_err && len_err, "R10", {proto_err, len_err}, 3);

        // R10 / R1: reset clears flags
        rst = 1'b1; tick(2);
        check(!proto_err && !len_err, "R10", {proto_err, len_err}, 0);

        // R5: threshold zero acts as one
        idle_thresh = 8'd0;
        rst = 1'b0;
        tick(3);
        check(bus_idle, "R5", bus_idle, 1);

        summary();
    end
endmodule